// File: doc/BRIEF.md
# Remote Terminal Subaddress Buffer Manager

This block turns a decoded remote-terminal command into RAM addresses for the data words of a message. It keeps a lookup table with one entry for each subaddress in each of three areas: receive, transmit and broadcast. Each entry either points at a fixed single-message block, or describes a circular buffer whose fill pointer moves on after each good message. Received broadcast data can be kept apart from ordinary received data, or can share the receive entries.

A command is taken in over a valid/ready handshake. `cmd_ready` is high only while no message is open. Once a command is accepted, the block offers one address per data word on a valid/ready output stream. The consumer may hold `addr_ready` low for as long as it needs, and the block then holds the offered address unchanged. A `msg_end` pulse, marked good or bad by `msg_err`, closes the message. It may arrive early to abort the message. The block then updates the circular pointer and, one cycle later, raises one-cycle end-of-message and buffer-wrap interrupt events.

The table is loaded through a plain write port. Writing an entry also clears its circular pointer.

Top module: `rt_sa_bufmgr`

## Requirements
- R1: Transmit commands use the transmit entry of their subaddress, and receive commands use the receive entry. The write port selects the area with `cfg_area`: 0 is receive, 1 is transmit, 2 is broadcast, and 3 writes nothing.
- R2: With `bcst_sep` high, a received broadcast command uses the broadcast entry. With `bcst_sep` low it uses the receive entry of the same subaddress and advances that entry's pointer.
- R3: In single-block mode (`cfg_circ`=0), word i of every message is addressed at base + i, whatever messages came before.
- R4: In circular mode the buffer holds 128 << `cfg_size` words, and codes 6 and 7 both mean 8192. Word i is addressed with the base's upper bits and the low bits set to (pointer + i) modulo the size; the base's low bits are ignored. A message may wrap in the middle.
- R5: After a circular message ends without error, the pointer advances by that message's word count, modulo the buffer size.
- R6: When a message ends with `msg_err` high, including an early abort, the pointer does not move.
- R7: A command word count of 0 means 32 data words.
- R8: `eom_irq` pulses for one cycle, in the cycle after `msg_end` is taken, when `irq_all_eom` is high, or when `irq_err_eom` and `msg_err` are both high, or when the entry's end-of-message enable is set.
- R9: `wrap_irq` pulses in the cycle after a good circular message whose entry has its wrap enable set and whose pointer plus word count reached or passed the buffer size.
- R10: `cmd_ready` is high only when idle. `addr_valid` rises in the cycle after the command is accepted and stays high until the last word is taken or the message ends. `addr_data` holds steady while valid and not ready. `msg_end` while idle has no effect.
- R11: A table write clears the entry's pointer. If it lands on the same entry in the same cycle as a pointer update, the write takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_area | input | 2 | Area: 0 rx, 1 tx, 2 broadcast |
| cfg_sa | input | 5 | Subaddress to write |
| cfg_circ | input | 1 | 1 = circular buffer, 0 = single block |
| cfg_size | input | 3 | Circular size code |
| cfg_base | input | 16 | Block or buffer base address |
| cfg_eom_en | input | 1 | Entry end-of-message interrupt enable |
| cfg_wrap_en | input | 1 | Entry wrap interrupt enable |
| bcst_sep | input | 1 | Keep broadcast data apart |
| irq_all_eom | input | 1 | Interrupt at every message end |
| irq_err_eom | input | 1 | Interrupt at messages ending in error |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high |
| cmd_tx | input | 1 | 1 = transmit command |
| cmd_bcst | input | 1 | Broadcast command |
| cmd_sa | input | 5 | Command subaddress |
| cmd_wc | input | 5 | Word count, 0 = 32 |
| addr_valid | output | 1 | Word address offered |
| addr_ready | input | 1 | Word address taken |
| addr_data | output | 16 | RAM address of the current word |
| msg_end | input | 1 | Message complete pulse |
| msg_err | input | 1 | Message ended in error |
| eom_irq | output | 1 | End-of-message interrupt event |
| wrap_irq | output | 1 | Circular wrap interrupt event |

## Verification
Two things can fall in the same cycle here: the pointer update made when a message closes, and a table write to the same entry. The bench drives `cfg_we` for the open message's entry in the very cycle that `msg_end` is high. It then judges the result from the start address of the next message on that entry, which must be the buffer base and not the advanced pointer. A second kind of overlap is also covered: `msg_end` arriving while addresses are still being offered. That case is judged by the return of `cmd_ready`, the interrupt pulse, and a pointer that has not moved.

// File: rtl/rt_sa_pkg.sv
package rt_sa_pkg;
  typedef enum logic [1:0] {
    AREA_RX = 2'd0,
    AREA_TX = 2'd1,
    AREA_BC = 2'd2
  } area_e;

  localparam int NUM_AREAS = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WAIT = 2'd2
  } msg_state_e;
endpackage

// File: rtl/rt_sa_table.sv
module rt_sa_table #(
  parameter int ENTRIES = 96,
  parameter int IDX_W   = 7,
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 13,
  parameter int CODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_circ,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic              wr_eom,
  input  logic              wr_wrap,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [OFF_W-1:0]  upd_off,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_circ,
  output logic [CODE_W-1:0] rd_code,
  output logic [ADDR_W-1:0] rd_base,
  output logic              rd_eom,
  output logic              rd_wrap,
  output logic [OFF_W-1:0]  rd_off
);
  logic              circ_q [ENTRIES];
  logic [CODE_W-1:0] code_q [ENTRIES];
  logic [ADDR_W-1:0] base_q [ENTRIES];
  logic              eom_q  [ENTRIES];
  logic              wrap_q [ENTRIES];
  logic [OFF_W-1:0]  off_q  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic wr_hit, upd_hit;
    assign wr_hit  = wr_en  && (wr_idx  == IDX_W'(e));
    assign upd_hit = upd_en && (upd_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        circ_q[e] <= 1'b0;
        code_q[e] <= '0;
        base_q[e] <= '0;
        eom_q[e]  <= 1'b0;
        wrap_q[e] <= 1'b0;
        off_q[e]  <= '0;
      end else if (wr_hit) begin
        circ_q[e] <= wr_circ;
        code_q[e] <= wr_code;
        base_q[e] <= wr_base;
        eom_q[e]  <= wr_eom;
        wrap_q[e] <= wr_wrap;
        off_q[e]  <= '0;
      end else if (upd_hit) begin
        off_q[e]  <= upd_off;
      end
    end
  end

  always_comb begin
    rd_circ = 1'b0;
    rd_code = '0;
    rd_base = '0;
    rd_eom  = 1'b0;
    rd_wrap = 1'b0;
    rd_off  = '0;
    if (int'(rd_idx) < ENTRIES) begin
      rd_circ = circ_q[rd_idx];
      rd_code = code_q[rd_idx];
      rd_base = base_q[rd_idx];
      rd_eom  = eom_q[rd_idx];
      rd_wrap = wrap_q[rd_idx];
      rd_off  = off_q[rd_idx];
    end
  end
endmodule

// File: rtl/rt_sa_addr_gen.sv
module rt_sa_addr_gen #(
  parameter int ADDR_W   = 16,
  parameter int OFF_W    = 13,
  parameter int CODE_W   = 3,
  parameter int MIN_LOG2 = 7,
  parameter int CNT_W    = 6
) (
  input  logic              circ,
  input  logic [CODE_W-1:0] code,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  input  logic [CNT_W-1:0]  step,
  output logic [ADDR_W-1:0] addr,
  output logic [OFF_W-1:0]  next_off,
  output logic              crossed
);
  localparam int MAX_CODE = OFF_W - MIN_LOG2;

  logic [CODE_W-1:0] code_c;
  logic [OFF_W:0]    size;
  logic [OFF_W-1:0]  mask;
  logic [OFF_W:0]    full;

  always_comb begin
    code_c   = (int'(code) > MAX_CODE) ? CODE_W'(MAX_CODE) : code;
    size     = (OFF_W+1)'(1) << (MIN_LOG2 + int'(code_c));
    mask     = OFF_W'(size - (OFF_W+1)'(1));
    full     = {1'b0, off & mask} + (OFF_W+1)'(step);
    crossed  = circ && (full >= size);
    next_off = full[OFF_W-1:0] & mask;
    if (circ)
      addr = (base & ~ADDR_W'(mask)) | ADDR_W'(next_off);
    else
      addr = base + ADDR_W'(step);
  end
endmodule

// File: rtl/rt_sa_msg_ctrl.sv
module rt_sa_msg_ctrl
  import rt_sa_pkg::*;
#(
  parameter int NUM_SA = 32,
  parameter int SA_W   = 5,
  parameter int WC_W   = 5,
  parameter int CNT_W  = 6,
  parameter int IDX_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bcst_sep,
  input  logic             cmd_valid,
  input  logic             cmd_tx,
  input  logic             cmd_bcst,
  input  logic [SA_W-1:0]  cmd_sa,
  input  logic [WC_W-1:0]  cmd_wc,
  output logic             cmd_ready,
  output logic             accept,
  output logic [IDX_W-1:0] sel_idx,
  output logic             addr_valid,
  input  logic             addr_ready,
  output logic [CNT_W-1:0] word_idx,
  output logic [CNT_W-1:0] word_total,
  input  logic             msg_end,
  input  logic             msg_err,
  output logic             fin,
  output logic             fin_err
);
  msg_state_e state_q;
  area_e      area;
  logic       last_word;

  always_comb begin
    if (cmd_tx)                    area = AREA_TX;
    else if (cmd_bcst && bcst_sep) area = AREA_BC;
    else                           area = AREA_RX;
    sel_idx = IDX_W'(int'(area) * NUM_SA) + IDX_W'(cmd_sa);
  end

  assign cmd_ready  = (state_q == ST_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign addr_valid = (state_q == ST_XFER);
  assign fin        = msg_end && (state_q != ST_IDLE);
  assign fin_err    = msg_err;
  assign last_word  = (word_idx == word_total - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      word_idx   <= '0;
      word_total <= '0;
    end else if (accept) begin
      state_q    <= ST_XFER;
      word_idx   <= '0;
      word_total <= (cmd_wc == '0) ? CNT_W'(1 << WC_W) : CNT_W'(cmd_wc);
    end else if (fin) begin
      state_q    <= ST_IDLE;
    end else if (addr_valid && addr_ready) begin
      if (last_word) state_q  <= ST_WAIT;
      else           word_idx <= word_idx + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rt_sa_bufmgr.sv
module rt_sa_bufmgr
  import rt_sa_pkg::*;
#(
  parameter int NUM_SA   = 32,
  parameter int ADDR_W   = 16,
  parameter int WC_W     = 5,
  parameter int CODE_W   = 3,
  parameter int MIN_LOG2 = 7,
  parameter int MAX_LOG2 = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_area,
  input  logic [$clog2(NUM_SA)-1:0] cfg_sa,
  input  logic              cfg_circ,
  input  logic [CODE_W-1:0] cfg_size,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_eom_en,
  input  logic              cfg_wrap_en,
  input  logic              bcst_sep,
  input  logic              irq_all_eom,
  input  logic              irq_err_eom,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_tx,
  input  logic              cmd_bcst,
  input  logic [$clog2(NUM_SA)-1:0] cmd_sa,
  input  logic [WC_W-1:0]   cmd_wc,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr_data,
  input  logic              msg_end,
  input  logic              msg_err,
  output logic              eom_irq,
  output logic              wrap_irq
);
  localparam int SA_W    = $clog2(NUM_SA);
  localparam int ENTRIES = NUM_AREAS * NUM_SA;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int OFF_W   = MAX_LOG2;
  localparam int CNT_W   = WC_W + 1;

  logic              accept, fin, fin_err;
  logic [IDX_W-1:0]  sel_idx, wr_idx;
  logic [CNT_W-1:0]  word_idx, word_total;
  logic              rd_circ, rd_eom, rd_wrap;
  logic [CODE_W-1:0] rd_code;
  logic [ADDR_W-1:0] rd_base;
  logic [OFF_W-1:0]  rd_off;

  logic              lat_circ, lat_eom, lat_wrap;
  logic [CODE_W-1:0] lat_code;
  logic [ADDR_W-1:0] lat_base;
  logic [OFF_W-1:0]  lat_off;
  logic [IDX_W-1:0]  lat_idx;

  logic [ADDR_W-1:0] adv_addr_unused;
  logic [OFF_W-1:0]  adv_off, word_off_unused;
  logic              adv_cross, word_cross_unused;
  logic              upd_en, wr_en;

  assign wr_en  = cfg_we && (cfg_area != 2'd3);
  assign wr_idx = IDX_W'(int'(cfg_area) * NUM_SA) + IDX_W'(cfg_sa);

  rt_sa_msg_ctrl #(
    .NUM_SA(NUM_SA), .SA_W(SA_W), .WC_W(WC_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bcst_sep(bcst_sep),
    .cmd_valid(cmd_valid), .cmd_tx(cmd_tx), .cmd_bcst(cmd_bcst),
    .cmd_sa(cmd_sa), .cmd_wc(cmd_wc), .cmd_ready(cmd_ready),
    .accept(accept), .sel_idx(sel_idx),
    .addr_valid(addr_valid), .addr_ready(addr_ready),
    .word_idx(word_idx), .word_total(word_total),
    .msg_end(msg_end), .msg_err(msg_err), .fin(fin), .fin_err(fin_err)
  );

  assign upd_en = fin && !fin_err && lat_circ;

  rt_sa_table #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .OFF_W(OFF_W), .CODE_W(CODE_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_circ(cfg_circ), .wr_code(cfg_size),
    .wr_base(cfg_base), .wr_eom(cfg_eom_en), .wr_wrap(cfg_wrap_en),
    .upd_en(upd_en), .upd_idx(lat_idx), .upd_off(adv_off),
    .rd_idx(sel_idx), .rd_circ(rd_circ), .rd_code(rd_code),
    .rd_base(rd_base), .rd_eom(rd_eom), .rd_wrap(rd_wrap), .rd_off(rd_off)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_circ <= 1'b0;
      lat_code <= '0;
      lat_base <= '0;
      lat_eom  <= 1'b0;
      lat_wrap <= 1'b0;
      lat_off  <= '0;
      lat_idx  <= '0;
    end else if (accept) begin
      lat_circ <= rd_circ;
      lat_code <= rd_code;
      lat_base <= rd_base;
      lat_eom  <= rd_eom;
      lat_wrap <= rd_wrap;
      lat_off  <= rd_off;
      lat_idx  <= sel_idx;
    end
  end

  rt_sa_addr_gen #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CODE_W(CODE_W),
    .MIN_LOG2(MIN_LOG2), .CNT_W(CNT_W)
  ) u_word (
    .circ(lat_circ), .code(lat_code), .base(lat_base), .off(lat_off),
    .step(word_idx), .addr(addr_data),
    .next_off(word_off_unused), .crossed(word_cross_unused)
  );

  rt_sa_addr_gen #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CODE_W(CODE_W),
    .MIN_LOG2(MIN_LOG2), .CNT_W(CNT_W)
  ) u_adv (
    .circ(lat_circ), .code(lat_code), .base(lat_base), .off(lat_off),
    .step(word_total), .addr(adv_addr_unused),
    .next_off(adv_off), .crossed(adv_cross)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eom_irq  <= 1'b0;
      wrap_irq <= 1'b0;
    end else begin
      eom_irq  <= fin && (irq_all_eom || (irq_err_eom && fin_err) || lat_eom);
      wrap_irq <= upd_en && lat_wrap && adv_cross;
    end
  end
endmodule

// File: rtl/rt_sa_bufmgr_chk.sv
module rt_sa_bufmgr_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr_data,
  input logic              msg_end,
  input logic              msg_err,
  input logic              eom_irq,
  input logic              wrap_irq
);
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready && !msg_end |=> addr_valid && $stable(addr_data)); // R10
  AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> addr_valid && !cmd_ready); // R10
  AST_IDLE_END_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end && cmd_ready |=> !eom_irq && !wrap_irq); // R10
  AST_EOM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    eom_irq |-> $past(msg_end) && !$past(cmd_ready)); // R8
  AST_EOM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eom_irq |=> !eom_irq); // R8
  AST_WRAP_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_irq |-> $past(msg_end) && !$past(msg_err)); // R9
endmodule

bind rt_sa_bufmgr rt_sa_bufmgr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_data(addr_data),
  .msg_end(msg_end), .msg_err(msg_err), .eom_irq(eom_irq), .wrap_irq(wrap_irq)
);

// File: tb/rt_sa_bufmgr_bench.sv
module rt_sa_bufmgr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cfg_we = 0, cfg_circ = 0, cfg_eom_en = 0, cfg_wrap_en = 0;
  logic [1:0]  cfg_area = 0;
  logic [4:0]  cfg_sa = 0;
  logic [2:0]  cfg_size = 0;
  logic [15:0] cfg_base = 0;
  logic        bcst_sep = 1, irq_all_eom = 0, irq_err_eom = 1;
  logic        cmd_valid = 0, cmd_tx = 0, cmd_bcst = 0;
  logic [4:0]  cmd_sa = 0, cmd_wc = 0;
  logic        addr_ready = 0, msg_end = 0, msg_err = 0;
  logic        cmd_ready, addr_valid, eom_irq, wrap_irq;
  logic [15:0] addr_data;

  rt_sa_bufmgr u_rt_sa_bufmgr (.*);

  int n_cmp = 0, n_bad = 0, cycles = 0;

  // vector: tx, bcst, sa[5], wc[5], err, first[16], last[16], eom, wrap
  localparam int NV = 12;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0,1'b0,5'd1,5'd4, 1'b0,16'h0100,16'h0103,1'b0,1'b0}, // R3 rx single
    {1'b0,1'b0,5'd1,5'd4, 1'b0,16'h0100,16'h0103,1'b0,1'b0}, // R3 same again
    {1'b1,1'b0,5'd3,5'd0, 1'b0,16'h0200,16'h021F,1'b1,1'b0}, // R7 R8 tx, entry eom
    {1'b0,1'b0,5'd2,5'd0, 1'b0,16'h0400,16'h041F,1'b0,1'b0}, // R4 circ
    {1'b0,1'b0,5'd2,5'd0, 1'b0,16'h0420,16'h043F,1'b0,1'b0}, // R5 advanced
    {1'b0,1'b0,5'd2,5'd16,1'b1,16'h0440,16'h044F,1'b1,1'b0}, // R6 R8 err
    {1'b0,1'b0,5'd2,5'd0, 1'b0,16'h0440,16'h045F,1'b0,1'b0}, // R6 not advanced
    {1'b0,1'b0,5'd2,5'd0, 1'b0,16'h0460,16'h047F,1'b0,1'b1}, // R9 wrap at end
    {1'b0,1'b0,5'd2,5'd20,1'b0,16'h0400,16'h0413,1'b0,1'b0}, // R5 back at start
    {1'b0,1'b1,5'd2,5'd3, 1'b0,16'h0800,16'h0802,1'b0,1'b0}, // R2 separated
    {1'b0,1'b0,5'd4,5'd8, 1'b0,16'h2000,16'h2007,1'b0,1'b0}, // R4 code 7, low base ignored
    {1'b1,1'b0,5'd1,5'd1, 1'b0,16'h0000,16'h0000,1'b0,1'b0}  // R1 tx sa1 apart from rx sa1
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] area, input logic [4:0] sa, input logic circ,
                     input logic [2:0] code, input logic [15:0] base,
                     input logic eom, input logic wrap);
    @(negedge clk);
    cfg_we = 1; cfg_area = area; cfg_sa = sa; cfg_circ = circ;
    cfg_size = code; cfg_base = base; cfg_eom_en = eom; cfg_wrap_en = wrap;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic start(input logic tx, input logic bc, input logic [4:0] sa,
                       input logic [4:0] wc);
    @(negedge clk);
    cmd_valid = 1; cmd_tx = tx; cmd_bcst = bc; cmd_sa = sa; cmd_wc = wc;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  // takes n words, stalling on some; returns first/last and stability flag
  task automatic take(input int n, output logic [15:0] first, output logic [15:0] last,
                      output bit ok);
    logic [15:0] held;
    ok = 1; first = 0; last = 0;
    for (int i = 0; i < n; i++) begin
      if (i % 5 == 2) begin
        addr_ready = 0;
        held = addr_data;
        @(negedge clk);
        if (!addr_valid || addr_data != held) ok = 0;
      end
      if (!addr_valid) ok = 0;
      if (i == 0) first = addr_data;
      last = addr_data;
      addr_ready = 1;
      @(negedge clk);
    end
    addr_ready = 0;
  endtask

  task automatic finish_msg(input logic err);
    msg_end = 1; msg_err = err;
    @(negedge clk);
    msg_end = 0; msg_err = 0;
  endtask

  task automatic msg(input logic tx, input logic bc, input logic [4:0] sa,
                     input logic [4:0] wc, input logic err, input string req,
                     input logic [15:0] ef, input logic [15:0] el,
                     input logic ee, input logic ew);
    logic [15:0] f, l;
    bit ok;
    start(tx, bc, sa, wc);
    take((wc == 0) ? 32 : int'(wc), f, l, ok);
    chk(ok, "R10", "stall hold", 32'(ok), 32'd1);
    chk(f == ef, req, "first addr", 32'(f), 32'(ef));
    chk(l == el, req, "last addr", 32'(l), 32'(el));
    finish_msg(err);
    chk(eom_irq == ee, req, "eom_irq", 32'(eom_irq), 32'(ee));
    chk(wrap_irq == ew, req, "wrap_irq", 32'(wrap_irq), 32'(ew));
  endtask

  task automatic first_only(input logic [4:0] sa, input logic [4:0] wc,
                            input logic [15:0] ef, input string req);
    logic [15:0] f, l;
    bit ok;
    start(0, 0, sa, wc);
    take((wc == 0) ? 32 : int'(wc), f, l, ok);
    chk(f == ef, req, "first addr", 32'(f), 32'(ef));
    finish_msg(0);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected < %0d", cycles, 100000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] f, l;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !addr_valid && !eom_irq && !wrap_irq, "R10", "reset state",
        {28'd0, cmd_ready, addr_valid, eom_irq, wrap_irq}, 32'h8);

    cfg(2'd0, 5'd1, 0, 3'd0, 16'h0100, 0, 0);  // R1 rx sa1 single
    cfg(2'd0, 5'd2, 1, 3'd0, 16'h0400, 0, 1);  // rx sa2 circ 128
    cfg(2'd1, 5'd3, 0, 3'd0, 16'h0200, 1, 0);  // tx sa3 single, eom
    cfg(2'd2, 5'd2, 0, 3'd0, 16'h0800, 0, 0);  // bcst sa2 single
    cfg(2'd0, 5'd4, 1, 3'd7, 16'h2345, 0, 1);  // rx sa4 circ 8192
    cfg(2'd3, 5'd1, 0, 3'd0, 16'hFFFF, 1, 1);  // R1 area 3: no write anywhere

    for (int v = 0; v < NV; v++) begin
      msg(VEC[v][46], VEC[v][45], VEC[v][44:40], VEC[v][39:35], VEC[v][34],
          $sformatf("R4/R5 vec%0d", v), VEC[v][33:18], VEC[v][17:2], VEC[v][1], VEC[v][0]);
    end

    // R2: separation off, broadcast shares rx sa2 (pointer 20 -> 22)
    bcst_sep = 0;
    msg(0, 1, 5'd2, 5'd2, 0, "R2", 16'h0414, 16'h0415, 0, 0);
    bcst_sep = 1;

    // R4: wrap in the middle of a message (22 -> 118, then 16 words)
    first_only(5'd2, 5'd0, 16'h0416, "R5");
    first_only(5'd2, 5'd0, 16'h0436, "R5");
    first_only(5'd2, 5'd0, 16'h0456, "R5");
    msg(0, 0, 5'd2, 5'd16, 0, "R4", 16'h0476, 16'h0405, 0, 1);

    // R10: msg_end while idle ignored
    @(negedge clk);
    msg_end = 1;
    @(negedge clk);
    msg_end = 0;
    chk(!eom_irq && !wrap_irq, "R10", "idle msg_end irq", {30'd0, eom_irq, wrap_irq}, 0);
    first_only(5'd2, 5'd1, 16'h0406, "R10");

    // R6: early abort with error, pointer stays at 7
    start(0, 0, 5'd2, 5'd8);
    take(2, f, l, ok);
    chk(addr_valid, "R6", "still open", 32'(addr_valid), 1);
    finish_msg(1);
    chk(eom_irq, "R8", "abort eom", 32'(eom_irq), 1);
    chk(cmd_ready, "R10", "ready after abort", 32'(cmd_ready), 1);
    first_only(5'd2, 5'd1, 16'h0407, "R6");

    // R8: global end-of-message enable
    irq_all_eom = 1;
    msg(0, 0, 5'd1, 5'd1, 0, "R8", 16'h0100, 16'h0100, 1, 0);
    irq_all_eom = 0;

    // R11: table write to the open entry in the msg_end cycle wins
    start(0, 0, 5'd2, 5'd4);
    take(4, f, l, ok);
    chk(f == 16'h0408, "R11", "pre first", 32'(f), 32'h0408);
    cfg_we = 1; cfg_area = 0; cfg_sa = 5'd2; cfg_circ = 1; cfg_size = 0;
    cfg_base = 16'h0400; cfg_eom_en = 0; cfg_wrap_en = 1;
    finish_msg(0);
    cfg_we = 0;
    first_only(5'd2, 5'd1, 16'h0400, "R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule